// File: doc/BRIEF.md
# Resumable Burst Bus Cycle Controller

This block sits between a processor core and a synchronous external bus. The core hands it one request at a time. A request is a single read, a single write, a four-beat line fill or a four-beat line copy-back. The controller then runs the bus cycle: an address strobe first, then one data beat for each sampled ready. A locked request keeps a lock qualifier on the bus for every phase that it drives.

A backoff input can take the bus away at any point, during any kind of cycle. The controller leaves the bus on the very next clock and waits while backoff stays high. When backoff drops, it re-issues the address strobe for the first beat that has not yet completed and carries on from there. Beats that already finished are never repeated, and a ready that arrives in the same clock as backoff does not count. The core gets exactly one done pulse per request, after the final beat, however many interruptions occurred.

Top module: `burst_backoff_master`

## Requirements
- R1: `reqReady` is high only while no request is in progress, including right after reset. A request is taken at a clock edge where `reqValid` and `reqReady` are both high. The `reqKind` codes are: 0 single read, 1 four-beat read, 2 four-beat write, 3 single write.
- R2: After a request is taken with `busBackoff` low, `busAds` is high for exactly the next cycle. The address is `{reqAddr[31:4], beat, 2'b00}`. For four-beat requests the first beat is 0. For single requests the beat is `reqAddr[3:2]`.
- R3: While `busAds` is high or a data phase is in progress, `busAddr[3:2]` shows the current beat. The beat advances by one only at an edge where the data phase samples `busRdy` high and `busBackoff` low. `busBlast` is high while the current beat is the last one outstanding.
- R4: At a clock edge where `busBackoff` is sampled high, the controller leaves the bus in the next cycle. `busAds`, `busWr`, `busLock`, `busBlast` and `busDataOe` are all low, and `busAddr` and `busDataOut` are zero. They stay that way while `busBackoff` remains high.
- R5: When `busBackoff` is sampled low while backed off, the next cycle has `busAds` high with the address of the first outstanding beat. Beats that already completed are not fetched or written again.
- R6: A `busRdy` sampled in the same clock as `busBackoff` is ignored. That beat is repeated after resumption.
- R7: For reads, the data sampled on beat k lands in `rspRData[32k+31:32k]`. Lanes that were not read are zero.
- R8: For writes, `busWr` is high in the address and data phases. `busDataOe` is high in data phases only. `busDataOut` carries lane k of `reqWData` during beat k.
- R9: `busLock` equals the request's `reqLock` in every address and data phase, including those after a resumption. It is low when the controller is off the bus.
- R10: `rspDone` is a one-cycle pulse in the cycle after the final beat's accepted ready. It occurs exactly once per request, no matter how many backoff interruptions happened.
- R11: A request taken while `busBackoff` is high goes straight to the backed-off state. Its first `busAds` appears only in the cycle after `busBackoff` is sampled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Core request valid |
| reqReady | output | 1 | Controller idle, request can be taken |
| reqKind | input | 2 | Request kind code |
| reqAddr | input | 32 | Request byte address |
| reqLock | input | 1 | Request is part of a locked sequence |
| reqWData | input | 128 | Write line, lane k for beat k |
| rspDone | output | 1 | Request complete pulse |
| rspRData | output | 128 | Read line, lane k from beat k |
| busAds | output | 1 | Address strobe |
| busAddr | output | 32 | Bus address |
| busWr | output | 1 | Write cycle qualifier |
| busLock | output | 1 | Lock qualifier |
| busBlast | output | 1 | Last outstanding beat |
| busDataOe | output | 1 | Write data drive enable |
| busDataOut | output | 32 | Write data |
| busDataIn | input | 32 | Read data |
| busRdy | input | 1 | Beat ready |
| busBackoff | input | 1 | Backoff, leave the bus |

## Verification
The assertions assume the following about the inputs:
- `busBackoff` and `busRdy` are synchronous and always hold known values.
- A ready only has meaning while a data phase is in progress.
- A request's fields are sampled only in the cycle it is taken.

The stimulus respects these assumptions by changing every input just after the falling edge and always driving defined values. Random backoff, ready and request traffic then covers interruptions in the address phase, in the data phase and at acceptance. Directed sequences pin down a ready that coincides with backoff, and a request that arrives while backoff is held.

// File: rtl/bkm_pkg.sv
package bkm_pkg;
  typedef enum logic [1:0] {
    KIND_RD1 = 2'd0,
    KIND_RDB = 2'd1,
    KIND_WRB = 2'd2,
    KIND_WR1 = 2'd3
  } reqKind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_OFF
  } busState_e;

  typedef struct packed {
    logic load;
    logic beatAdv;
    logic addrPhase;
    logic dataPhase;
  } ctrlStrb_t;
endpackage

// File: rtl/bkm_ctrl.sv
module bkm_ctrl
  import bkm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      busBackoff,
  input  logic      busRdy,
  input  logic      lastBeat,
  output ctrlStrb_t strb,
  output logic      reqReady,
  output logic      rspDone
);
  busState_e state, stateNext;
  logic      doneNext;

  always_comb begin
    stateNext = state;
    doneNext  = 1'b0;
    strb      = '0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.load = 1'b1;
          stateNext = busBackoff ? ST_OFF : ST_ADDR;
        end
      end
      ST_ADDR: begin
        strb.addrPhase = 1'b1;
        stateNext = busBackoff ? ST_OFF : ST_DATA;
      end
      ST_DATA: begin
        strb.dataPhase = 1'b1;
        if (busBackoff) begin
          stateNext = ST_OFF;
        end else if (busRdy) begin
          strb.beatAdv = 1'b1;
          if (lastBeat) begin
            stateNext = ST_IDLE;
            doneNext  = 1'b1;
          end
        end
      end
      ST_OFF: begin
        if (!busBackoff) stateNext = ST_ADDR;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      rspDone <= 1'b0;
    end else begin
      state   <= stateNext;
      rspDone <= doneNext;
    end
  end

  assign reqReady = (state == ST_IDLE);

  AST_OFF_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    busBackoff |=> !(strb.addrPhase || strb.dataPhase)); // R4
  AST_RESUME_ADS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF && !busBackoff) |=> strb.addrPhase); // R5
  AST_ADS_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.addrPhase |=> !strb.addrPhase); // R2
  AST_DONE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> $past(strb.beatAdv && lastBeat)); // R10
endmodule

// File: rtl/bkm_datapath.sv
module bkm_datapath
  import bkm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrb_t                strb,
  input  logic [1:0]               reqKind,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic                     reqLock,
  input  logic [DATA_W*BEATS-1:0]  reqWData,
  input  logic [DATA_W-1:0]        busDataIn,
  output logic                     lastBeat,
  output logic [ADDR_W-1:0]        busAddr,
  output logic                     busWr,
  output logic                     busLock,
  output logic                     busBlast,
  output logic                     busDataOe,
  output logic [DATA_W-1:0]        busDataOut,
  output logic [DATA_W*BEATS-1:0]  rspRData
);
  localparam int BEAT_BITS = $clog2(BEATS);
  localparam int BYTE_OFF  = $clog2(DATA_W / 8);
  localparam int LINE_OFF  = BEAT_BITS + BYTE_OFF;
  localparam int CNT_W     = BEAT_BITS + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BEATS);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic [ADDR_W-1:LINE_OFF] baseAddr;
  logic [BEAT_BITS-1:0]     beatIdx;
  logic [CNT_W-1:0]         beatsLeft;
  logic                     isWrite;
  logic                     isLock;
  logic                     isBurst;
  logic [DATA_W-1:0]        wLane [BEATS];
  logic                     driving;

  assign isBurst = (reqKind == KIND_RDB) || (reqKind == KIND_WRB);
  assign driving = strb.addrPhase || strb.dataPhase;
  assign lastBeat = (beatsLeft == ONE_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr  <= '0;
      beatIdx   <= '0;
      beatsLeft <= '0;
      isWrite   <= 1'b0;
      isLock    <= 1'b0;
    end else if (strb.load) begin
      baseAddr  <= reqAddr[ADDR_W-1:LINE_OFF];
      beatIdx   <= isBurst ? '0 : reqAddr[LINE_OFF-1:BYTE_OFF];
      beatsLeft <= isBurst ? FULL_CNT : ONE_CNT;
      isWrite   <= (reqKind == KIND_WRB) || (reqKind == KIND_WR1);
      isLock    <= reqLock;
    end else if (strb.beatAdv) begin
      beatIdx   <= beatIdx + 1'b1;
      beatsLeft <= beatsLeft - 1'b1;
    end
  end

  for (genvar k = 0; k < BEATS; k++) begin : g_lane
    logic [DATA_W-1:0] wReg;
    logic [DATA_W-1:0] rReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wReg <= '0;
        rReg <= '0;
      end else if (strb.load) begin
        wReg <= reqWData[k*DATA_W +: DATA_W];
        rReg <= '0;
      end else if (strb.beatAdv && !isWrite && beatIdx == BEAT_BITS'(k)) begin
        rReg <= busDataIn;
      end
    end
    assign wLane[k] = wReg;
    assign rspRData[k*DATA_W +: DATA_W] = rReg;
  end

  assign busAddr    = driving ? {baseAddr, beatIdx, {BYTE_OFF{1'b0}}} : '0;
  assign busWr      = driving && isWrite;
  assign busLock    = driving && isLock;
  assign busBlast   = driving && lastBeat;
  assign busDataOe  = strb.dataPhase && isWrite;
  assign busDataOut = busDataOe ? wLane[beatIdx] : '0;

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.beatAdv) |=> ($stable(beatIdx) && $stable(beatsLeft))); // R3
  AST_LOCK_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(isLock)); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.beatAdv |-> (beatsLeft != '0)); // R10
endmodule

// File: rtl/burst_backoff_master.sv
module burst_backoff_master
  import bkm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output logic         reqReady,
  input  logic [1:0]   reqKind,
  input  logic [31:0]  reqAddr,
  input  logic         reqLock,
  input  logic [127:0] reqWData,
  output logic         rspDone,
  output logic [127:0] rspRData,
  output logic         busAds,
  output logic [31:0]  busAddr,
  output logic         busWr,
  output logic         busLock,
  output logic         busBlast,
  output logic         busDataOe,
  output logic [31:0]  busDataOut,
  input  logic [31:0]  busDataIn,
  input  logic         busRdy,
  input  logic         busBackoff
);
  ctrlStrb_t strb;
  logic      lastBeat;

  bkm_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .busBackoff (busBackoff),
    .busRdy     (busRdy),
    .lastBeat   (lastBeat),
    .strb       (strb),
    .reqReady   (reqReady),
    .rspDone    (rspDone)
  );

  bkm_datapath #(.ADDR_W(32), .DATA_W(32), .BEATS(4)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqKind    (reqKind),
    .reqAddr    (reqAddr),
    .reqLock    (reqLock),
    .reqWData   (reqWData),
    .busDataIn  (busDataIn),
    .lastBeat   (lastBeat),
    .busAddr    (busAddr),
    .busWr      (busWr),
    .busLock    (busLock),
    .busBlast   (busBlast),
    .busDataOe  (busDataOe),
    .busDataOut (busDataOut),
    .rspRData   (rspRData)
  );

  assign busAds = strb.addrPhase;
endmodule

// File: tb/burst_backoff_master_tb.sv
module burst_backoff_master_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [1:0]   reqKind = 2'd0;
  logic [31:0]  reqAddr = '0;
  logic         reqLock = 1'b0;
  logic [127:0] reqWData = '0;
  logic         rspDone;
  logic [127:0] rspRData;
  logic         busAds, busWr, busLock, busBlast, busDataOe;
  logic [31:0]  busAddr, busDataOut;
  logic [31:0]  busDataIn = '0;
  logic         busRdy = 1'b0;
  logic         busBackoff = 1'b0;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  burst_backoff_master u_dut (.*);

  // behavioural reference: phase 0 address, 1 data, 2 off
  bit           mBusy;
  int           mPhase;
  logic [27:0]  mBase;
  int           mBeats[$];
  bit           mWrite, mLock, mDone;
  logic [127:0] mLine, mWLine;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy = 0; mPhase = 0; mBeats.delete(); mWrite = 0; mLock = 0;
      mDone = 0; mLine = '0; mWLine = '0; mBase = '0;
    end else begin
      mDone = 0;
      if (!mBusy) begin
        if (reqValid) begin
          mBusy = 1; mBase = reqAddr[31:4]; mLock = reqLock; mWLine = reqWData;
          mWrite = (reqKind == 2'd2) || (reqKind == 2'd3);
          mLine = '0;
          mBeats.delete();
          if (reqKind == 2'd1 || reqKind == 2'd2) mBeats = '{0, 1, 2, 3};
          else mBeats.push_back(int'(reqAddr[3:2]));
          mPhase = busBackoff ? 2 : 0;
        end
      end else if (mPhase == 0) begin
        mPhase = busBackoff ? 2 : 1;
      end else if (mPhase == 1) begin
        if (busBackoff) mPhase = 2;
        else if (busRdy) begin
          if (!mWrite) mLine[mBeats[0]*32 +: 32] = busDataIn;
          void'(mBeats.pop_front());
          if (mBeats.size() == 0) begin mBusy = 0; mDone = 1; end
        end
      end else begin
        if (!busBackoff) mPhase = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll();
    bit drv = mBusy && (mPhase == 0 || mPhase == 1);
    logic [31:0] eAddr = drv ? {mBase, 2'(mBeats[0]), 2'b00} : 32'h0;
    bit eOe = mBusy && mPhase == 1 && mWrite;
    logic [31:0] eData = eOe ? mWLine[mBeats[0]*32 +: 32] : 32'h0;
    chk(reqReady == !mBusy, "R1 reqReady", 128'(reqReady), 128'(!mBusy));
    chk(busAds == (mBusy && mPhase == 0), "R2/R5 busAds", 128'(busAds), 128'(mBusy && mPhase == 0));
    chk(busAddr == eAddr, "R3/R4 busAddr", 128'(busAddr), 128'(eAddr));
    chk(busBlast == (drv && mBeats.size() == 1), "R3 busBlast", 128'(busBlast), 128'(drv && mBeats.size() == 1));
    chk(busWr == (drv && mWrite), "R8 busWr", 128'(busWr), 128'(drv && mWrite));
    chk(busDataOe == eOe, "R8 busDataOe", 128'(busDataOe), 128'(eOe));
    chk(busDataOut == eData, "R8 busDataOut", 128'(busDataOut), 128'(eData));
    chk(busLock == (drv && mLock), "R9 busLock", 128'(busLock), 128'(drv && mLock));
    chk(rspDone == mDone, "R10 rspDone", 128'(rspDone), 128'(mDone));
    if (mDone) chk(rspRData == mLine, "R7 rspRData", rspRData, mLine);
  endtask

  task automatic step(input bit v, input logic [1:0] k, input logic [31:0] a, input bit lk,
                      input logic [127:0] wd, input bit bo, input bit rd, input logic [31:0] din);
    reqValid = v; reqKind = k; reqAddr = a; reqLock = lk; reqWData = wd;
    busBackoff = bo; busRdy = rd; busDataIn = din;
    @(posedge clk);
    @(negedge clk);
    checkAll();
  endtask

  task automatic idleStep(input bit bo, input bit rd, input logic [31:0] din);
    step(1'b0, 2'd0, 32'h0, 1'b0, '0, bo, rd, din);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(reqReady == 1'b1, "R1 reset reqReady", 128'(reqReady), 128'(1));
    chk(busAds == 1'b0 && busDataOe == 1'b0 && rspDone == 1'b0, "R1 reset outputs",
        128'({busAds, busDataOe, rspDone}), 128'(0));
    checkAll();

    // R6: ready coinciding with backoff is ignored, burst read resumes at beat 1
    step(1'b1, 2'd1, 32'h0000_1008, 1'b1, '0, 1'b0, 1'b0, 32'h0);
    chk(busAddr == 32'h0000_1000, "R2 burst start address", 128'(busAddr), 128'h1000);
    idleStep(1'b0, 1'b0, 32'h0);
    idleStep(1'b0, 1'b1, 32'hA0A0_0000);
    idleStep(1'b1, 1'b1, 32'hDEAD_BEEF);
    chk(busAds == 1'b0 && busLock == 1'b0, "R4 off after backoff", 128'({busAds, busLock}), 128'(0));
    idleStep(1'b1, 1'b0, 32'h0);
    idleStep(1'b0, 1'b0, 32'h0);
    chk(busAds == 1'b1 && busAddr == 32'h0000_1004, "R6 resume at ignored beat",
        128'({busAds, busAddr}), 128'({1'b1, 32'h0000_1004}));
    chk(busLock == 1'b1, "R9 lock on resumed cycle", 128'(busLock), 128'(1));
    idleStep(1'b0, 1'b0, 32'h0);
    idleStep(1'b0, 1'b1, 32'hA1A1_1111);
    idleStep(1'b0, 1'b1, 32'hA2A2_2222);
    idleStep(1'b0, 1'b1, 32'hA3A3_3333);
    chk(rspDone == 1'b1 && rspRData == {32'hA3A3_3333, 32'hA2A2_2222, 32'hA1A1_1111, 32'hA0A0_0000},
        "R7 line after interruption", rspRData, {32'hA3A3_3333, 32'hA2A2_2222, 32'hA1A1_1111, 32'hA0A0_0000});

    // R11: request taken under backoff waits off the bus
    step(1'b1, 2'd2, 32'h0000_2000, 1'b0, {32'h4, 32'h3, 32'h2, 32'h1}, 1'b1, 1'b0, 32'h0);
    chk(busAds == 1'b0 && reqReady == 1'b0, "R11 no strobe under backoff",
        128'({busAds, reqReady}), 128'(0));
    idleStep(1'b1, 1'b0, 32'h0);
    chk(busAds == 1'b0, "R11 still off", 128'(busAds), 128'(0));
    idleStep(1'b0, 1'b0, 32'h0);
    chk(busAds == 1'b1 && busAddr == 32'h0000_2000, "R11 strobe after release",
        128'({busAds, busAddr}), 128'({1'b1, 32'h0000_2000}));
    idleStep(1'b0, 1'b0, 32'h0);
    chk(busDataOut == 32'h1, "R8 first write lane", 128'(busDataOut), 128'h1);
    for (int i = 0; i < 4; i++) idleStep(1'b0, 1'b1, 32'h0);
    chk(rspDone == 1'b1, "R10 write done", 128'(rspDone), 128'(1));
    idleStep(1'b0, 1'b0, 32'h0);
    chk(rspDone == 1'b0, "R10 single pulse", 128'(rspDone), 128'(0));

    // single read from lane 2
    step(1'b1, 2'd0, 32'h0000_3008, 1'b0, '0, 1'b0, 1'b0, 32'h0);
    chk(busBlast == 1'b1 && busAddr == 32'h0000_3008, "R2 single address",
        128'({busBlast, busAddr}), 128'({1'b1, 32'h0000_3008}));
    idleStep(1'b0, 1'b0, 32'h0);
    idleStep(1'b0, 1'b1, 32'h5555_AAAA);
    chk(rspRData == {32'h0, 32'h5555_AAAA, 64'h0}, "R7 single read lane",
        rspRData, {32'h0, 32'h5555_AAAA, 64'h0});

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 3) != 0, 2'($urandom % 4), $urandom, 1'($urandom % 2),
           {$urandom, $urandom, $urandom, $urandom},
           ($urandom % 5) == 0, ($urandom % 2) == 0, $urandom);
    end
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired act=running exp=finished");
    finishRun();
  end
endmodule